// File: doc/BRIEF.md
# Serial Status Flag and Request Generator

This block keeps the status flags of an I2C or clock-synchronous serial controller and turns them into level interrupt requests and transfer-activation triggers for a data-transfer controller. Single-cycle event strobes from the shift and bus logic set the flags. The flags are cleared in two ways. The three data flags clear as a side effect of CPU accesses to the data registers, or of controller accesses while a counted transfer is running. The three bus-event flags clear only when the CPU writes 0 to a flag that it has read as 1.

Every request is registered. Each one is the AND of a flag and its enable, taken one clock after the flag. The serial mode decides which requests may appear at all. All pins are plain control and status signals. No data moves through the block, so it has no valid/ready interface and applies no back-pressure. Each strobe acts in the clock cycle in which it is high.

Top module: `ser_status_irq`

## Requirements
- R1: After reset, status_o equals 6'b000001: bit 0 (tx-empty) is set and bits 1..5 are clear. Every request and trigger output is 0.
- R2: The tx-empty flag (status_o[0]) is set by ev_tx_load and cleared by cpu_tx_wr. When both happen in the same cycle, the flag ends up set.
- R3: The tx-end flag (status_o[1]) is set by ev_tx_end and cleared by cpu_tx_wr. A set in the same cycle wins.
- R4: The rx-full flag (status_o[2]) is set by ev_rx_full and cleared by cpu_rx_rd. A set in the same cycle wins.
- R5: xfer_tx_wr clears status_o[0] and status_o[1], and xfer_rx_rd clears status_o[2], but only while xfer_busy is high. When xfer_busy is low, these strobes have no effect.
- R6: Each request output is the registered AND of its flag and its enable, so it appears one clock after the flag. It holds until either the flag or the enable drops.
- R7: irq_stop and irq_nack are forced to 0 while mode_i2c is 0. irq_txe, irq_tend and irq_rxf behave the same in both modes.
- R8: irq_nack is raised when en_nack is set and either the NACK flag (status_o[4]) or the arbitration/overrun flag (status_o[5]) is set. Either ev_arb_lost or ev_overrun sets status_o[5].
- R9: The STOP (status_o[3]), NACK and arbitration/overrun flags clear only through a stat_wr whose stat_wdata bit is 0 (bit 0 = STOP, bit 1 = NACK, bit 2 = arb/overrun). That stat_wr must follow a stat_rd that saw the flag set, with no other stat_wr between them. Writing 1, or writing 0 without a fresh read, leaves the flag set.
- R10: Only tx-empty and rx-full drive the triggers: trig_tx is the registered value of status_o[0] & en_txe, and trig_rx is the registered value of status_o[2] & en_rxf. No other flag ever raises a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i2c | input | 1 | 1 = I2C mode, 0 = clock-synchronous mode |
| ev_tx_load | input | 1 | Pending transmit byte moved into the shifter |
| ev_tx_end | input | 1 | Transmission finished |
| ev_rx_full | input | 1 | Byte received |
| ev_stop | input | 1 | STOP condition detected |
| ev_nack | input | 1 | NACK received |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_overrun | input | 1 | Receive overrun |
| cpu_tx_wr | input | 1 | CPU write to the transmit data register |
| cpu_rx_rd | input | 1 | CPU read of the receive data register |
| xfer_busy | input | 1 | Counted controller transfer in progress |
| xfer_tx_wr | input | 1 | Controller write to the transmit data register |
| xfer_rx_rd | input | 1 | Controller read of the receive data register |
| stat_rd | input | 1 | CPU read of the status register |
| stat_wr | input | 1 | CPU write of the status register |
| stat_wdata | input | 3 | Write data: bit 0 STOP, bit 1 NACK, bit 2 arb/overrun |
| en_txe | input | 1 | Tx-empty request enable |
| en_tend | input | 1 | Tx-end request enable |
| en_rxf | input | 1 | Rx-full request enable |
| en_stop | input | 1 | STOP request enable |
| en_nack | input | 1 | NACK / arb / overrun request enable |
| status_o | output | 6 | Flags: 0 tx-empty, 1 tx-end, 2 rx-full, 3 STOP, 4 NACK, 5 arb/overrun |
| irq_txe | output | 1 | Tx-empty request |
| irq_tend | output | 1 | Tx-end request |
| irq_rxf | output | 1 | Rx-full request |
| irq_stop | output | 1 | STOP request |
| irq_nack | output | 1 | NACK / arb / overrun request |
| trig_tx | output | 1 | Transmit activation for the transfer controller |
| trig_rx | output | 1 | Receive activation for the transfer controller |

## Verification
A wrong flag shows on status_o one clock after the strobe that caused it. The same error reaches the matching request or trigger one clock later. A read-arm bit that is wrongly set or wrongly cleared has no visible effect until the next status write. It then shows as a sticky flag that drops when it should stay set, or stays set when it should drop. For that reason the bench exercises write-without-read, write-of-one and read-then-write-zero separately. A wrong mode gate is only visible while a STOP or NACK flag is pending with its enable set, so those cases are exercised in both modes.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;
  localparam int NUM_DATA   = 3;
  localparam int NUM_STICKY = 3;
  localparam int NUM_STAT   = NUM_DATA + NUM_STICKY;
  localparam int DF_TXE  = 0;
  localparam int DF_TEND = 1;
  localparam int DF_RXF  = 2;
  localparam int SK_STOP = 0;
  localparam int SK_NACK = 1;
  localparam int SK_AL   = 2;

  typedef struct packed {
    logic rxf;
    logic tend;
    logic txe;
  } data_flags_t;
endpackage

// File: rtl/ser_data_flags.sv
module ser_data_flags
  import ser_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_tx_load,
  input  logic        ev_tx_end,
  input  logic        ev_rx_full,
  input  logic        cpu_tx_wr,
  input  logic        cpu_rx_rd,
  input  logic        xfer_busy,
  input  logic        xfer_tx_wr,
  input  logic        xfer_rx_rd,
  output data_flags_t flags
);
  logic tx_clr, rx_clr;

  // controller accesses count only while a counted transfer runs
  assign tx_clr = cpu_tx_wr | (xfer_busy & xfer_tx_wr);
  assign rx_clr = cpu_rx_rd | (xfer_busy & xfer_rx_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags.txe  <= 1'b1;
      flags.tend <= 1'b0;
      flags.rxf  <= 1'b0;
    end else begin
      // hardware set has priority over the access-side clear
      if (ev_tx_load)  flags.txe  <= 1'b1;
      else if (tx_clr) flags.txe  <= 1'b0;
      if (ev_tx_end)   flags.tend <= 1'b1;
      else if (tx_clr) flags.tend <= 1'b0;
      if (ev_rx_full)  flags.rxf  <= 1'b1;
      else if (rx_clr) flags.rxf  <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_sticky_bank.sv
module ser_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    logic flag_q, armed_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q  <= 1'b0;
        armed_q <= 1'b0;
      end else begin
        if (set_i[g]) begin
          flag_q  <= 1'b1;
          armed_q <= 1'b0;
        end else if (wr_i) begin
          if (armed_q && !wdata_i[g]) flag_q <= 1'b0;
          armed_q <= 1'b0;
        end else if (rd_i && flag_q) begin
          armed_q <= 1'b1;
        end
      end
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/ser_req_gate.sv
module ser_req_gate
  import ser_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_i2c,
  input  data_flags_t           dflags,
  input  logic [NUM_STICKY-1:0] sflags,
  input  logic                  en_txe,
  input  logic                  en_tend,
  input  logic                  en_rxf,
  input  logic                  en_stop,
  input  logic                  en_nack,
  output logic                  irq_txe,
  output logic                  irq_tend,
  output logic                  irq_rxf,
  output logic                  irq_stop,
  output logic                  irq_nack,
  output logic                  trig_tx,
  output logic                  trig_rx
);
  logic txe_c, rxf_c, bus_err;

  assign txe_c   = dflags.txe & en_txe;
  assign rxf_c   = dflags.rxf & en_rxf;
  assign bus_err = sflags[SK_NACK] | sflags[SK_AL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_txe  <= 1'b0;
      irq_tend <= 1'b0;
      irq_rxf  <= 1'b0;
      irq_stop <= 1'b0;
      irq_nack <= 1'b0;
      trig_tx  <= 1'b0;
      trig_rx  <= 1'b0;
    end else begin
      irq_txe  <= txe_c;
      irq_tend <= dflags.tend & en_tend;
      irq_rxf  <= rxf_c;
      irq_stop <= mode_i2c & sflags[SK_STOP] & en_stop;
      irq_nack <= mode_i2c & bus_err & en_nack;
      trig_tx  <= txe_c;
      trig_rx  <= rxf_c;
    end
  end
endmodule

// File: rtl/ser_status_irq.sv
module ser_status_irq
  import ser_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_i2c,
  input  logic                  ev_tx_load,
  input  logic                  ev_tx_end,
  input  logic                  ev_rx_full,
  input  logic                  ev_stop,
  input  logic                  ev_nack,
  input  logic                  ev_arb_lost,
  input  logic                  ev_overrun,
  input  logic                  cpu_tx_wr,
  input  logic                  cpu_rx_rd,
  input  logic                  xfer_busy,
  input  logic                  xfer_tx_wr,
  input  logic                  xfer_rx_rd,
  input  logic                  stat_rd,
  input  logic                  stat_wr,
  input  logic [NUM_STICKY-1:0] stat_wdata,
  input  logic                  en_txe,
  input  logic                  en_tend,
  input  logic                  en_rxf,
  input  logic                  en_stop,
  input  logic                  en_nack,
  output logic [NUM_STAT-1:0]   status_o,
  output logic                  irq_txe,
  output logic                  irq_tend,
  output logic                  irq_rxf,
  output logic                  irq_stop,
  output logic                  irq_nack,
  output logic                  trig_tx,
  output logic                  trig_rx
);
  data_flags_t           dflags;
  logic [NUM_STICKY-1:0] sset, sflags;

  assign sset[SK_STOP] = ev_stop;
  assign sset[SK_NACK] = ev_nack;
  assign sset[SK_AL]   = ev_arb_lost | ev_overrun;

  ser_data_flags u_data (
    .clk(clk), .rst_n(rst_n),
    .ev_tx_load(ev_tx_load), .ev_tx_end(ev_tx_end), .ev_rx_full(ev_rx_full),
    .cpu_tx_wr(cpu_tx_wr), .cpu_rx_rd(cpu_rx_rd),
    .xfer_busy(xfer_busy), .xfer_tx_wr(xfer_tx_wr), .xfer_rx_rd(xfer_rx_rd),
    .flags(dflags)
  );

  ser_sticky_bank #(.N(NUM_STICKY)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_i(sset),
    .rd_i(stat_rd), .wr_i(stat_wr), .wdata_i(stat_wdata),
    .flag_o(sflags)
  );

  ser_req_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode_i2c(mode_i2c),
    .dflags(dflags), .sflags(sflags),
    .en_txe(en_txe), .en_tend(en_tend), .en_rxf(en_rxf),
    .en_stop(en_stop), .en_nack(en_nack),
    .irq_txe(irq_txe), .irq_tend(irq_tend), .irq_rxf(irq_rxf),
    .irq_stop(irq_stop), .irq_nack(irq_nack),
    .trig_tx(trig_tx), .trig_rx(trig_rx)
  );

  assign status_o = {sflags, dflags.rxf, dflags.tend, dflags.txe};
endmodule

// File: rtl/ser_status_irq_chk.sv
module ser_status_irq_chk
  import ser_irq_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  mode_i2c,
  input logic                  ev_tx_load,
  input logic                  ev_rx_full,
  input logic                  cpu_tx_wr,
  input logic                  cpu_rx_rd,
  input logic                  xfer_busy,
  input logic                  xfer_rx_rd,
  input logic                  stat_wr,
  input logic                  en_rxf,
  input logic [NUM_STAT-1:0]   status_o,
  input logic                  irq_rxf,
  input logic                  irq_stop,
  input logic                  irq_nack,
  input logic                  trig_tx
);
  assert_txe_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_load |=> status_o[0]);
  assert_txe_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_tx_wr && !ev_tx_load |=> !status_o[0]);
  assert_idle_ctrl_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_rx_rd && !xfer_busy && !cpu_rx_rd && !ev_rx_full |=> $stable(status_o[2]));
  assert_req_follows_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxf |-> $past(status_o[2] && en_rxf));
  assert_sync_mode_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i2c |=> !irq_stop && !irq_nack);
  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[3] && !stat_wr |=> status_o[3]);
  assert_trig_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_tx |-> $past(status_o[0]));
endmodule

bind ser_status_irq ser_status_irq_chk u_chk (.*);

// File: tb/sim_ser_status_irq.sv
`timescale 1ns/1ps
module sim_ser_status_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_i2c = 1'b1;
  logic ev_tx_load = 0, ev_tx_end = 0, ev_rx_full = 0, ev_stop = 0;
  logic ev_nack = 0, ev_arb_lost = 0, ev_overrun = 0;
  logic cpu_tx_wr = 0, cpu_rx_rd = 0, xfer_busy = 0, xfer_tx_wr = 0, xfer_rx_rd = 0;
  logic stat_rd = 0, stat_wr = 0;
  logic [2:0] stat_wdata = 3'b000;
  logic en_txe = 0, en_tend = 0, en_rxf = 0, en_stop = 0, en_nack = 0;
  logic [5:0] status_o;
  logic irq_txe, irq_tend, irq_rxf, irq_stop, irq_nack, trig_tx, trig_rx;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ser_status_irq u0 (.*);

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 6'b000001);
    chk("R1 requests", {irq_txe, irq_tend, irq_rxf, irq_stop, irq_nack, trig_tx}, 6'b0);
  endtask

  task automatic t_tx_empty();
    en_txe = 1; step(2);
    chk("R6 irq_txe on", irq_txe, 1);
    chk("R10 trig_tx on", trig_tx, 1);
    cpu_tx_wr = 1; step(); cpu_tx_wr = 0;
    chk("R2 txe cleared", status_o[0], 0);
    step();
    chk("R6 irq_txe off", irq_txe, 0);
    cpu_tx_wr = 1; ev_tx_load = 1; step(); cpu_tx_wr = 0; ev_tx_load = 0;
    chk("R2 set wins", status_o[0], 1);
    en_txe = 0; step(2);
    chk("R6 enable drop", irq_txe, 0);
  endtask

  task automatic t_tx_end();
    en_tend = 1; en_txe = 1;
    cpu_tx_wr = 1; step(); cpu_tx_wr = 0;
    ev_tx_end = 1; step(); ev_tx_end = 0;
    chk("R3 tend set", status_o[1:0], 2'b10);
    step();
    chk("R3 irq_tend", irq_tend, 1);
    chk("R10 no trig from tend", trig_tx, 0);
    cpu_tx_wr = 1; step(); cpu_tx_wr = 0;
    chk("R3 tend cleared", status_o[1], 0);
    ev_tx_load = 1; step(); ev_tx_load = 0;
    en_tend = 0; en_txe = 0; step();
  endtask

  task automatic t_rx_full();
    en_rxf = 1;
    ev_rx_full = 1; step(); ev_rx_full = 0;
    chk("R4 rxf set", status_o[2], 1);
    step();
    chk("R10 trig_rx", {irq_rxf, trig_rx}, 2'b11);
    cpu_rx_rd = 1; step(); cpu_rx_rd = 0;
    chk("R4 rxf cleared", status_o[2], 0);
    step();
    chk("R6 irq_rxf off", {irq_rxf, trig_rx}, 2'b00);
    en_rxf = 0;
  endtask

  task automatic t_ctrl_access();
    ev_rx_full = 1; ev_tx_end = 1; step(); ev_rx_full = 0; ev_tx_end = 0;
    xfer_rx_rd = 1; xfer_tx_wr = 1; step(); xfer_rx_rd = 0; xfer_tx_wr = 0;
    chk("R5 idle ignored", status_o[2:0], 3'b111);
    xfer_busy = 1;
    xfer_rx_rd = 1; xfer_tx_wr = 1; step(); xfer_rx_rd = 0; xfer_tx_wr = 0;
    chk("R5 busy clears", status_o[2:0], 3'b000);
    xfer_busy = 0;
    ev_tx_load = 1; step(); ev_tx_load = 0;
  endtask

  task automatic t_mode();
    en_stop = 1; en_txe = 1; mode_i2c = 0;
    ev_stop = 1; step(); ev_stop = 0;
    chk("R9 stop flag set", status_o[3], 1);
    step();
    chk("R7 stop gated", irq_stop, 0);
    chk("R7 txe in sync mode", irq_txe, 1);
    mode_i2c = 1; step(2);
    chk("R7 stop in i2c", irq_stop, 1);
    en_txe = 0;
  endtask

  task automatic t_sticky();
    stat_wr = 1; stat_wdata = 3'b000; step(); stat_wr = 0;
    chk("R9 write0 no read", status_o[3], 1);
    stat_rd = 1; step(); stat_rd = 0;
    stat_wr = 1; stat_wdata = 3'b111; step(); stat_wr = 0;
    chk("R9 write1 ignored", status_o[3], 1);
    stat_wr = 1; stat_wdata = 3'b000; step(); stat_wr = 0;
    chk("R9 stale read", status_o[3], 1);
    stat_rd = 1; step(); stat_rd = 0;
    stat_wr = 1; stat_wdata = 3'b110; step(); stat_wr = 0;
    chk("R9 cleared", status_o[3], 0);
    step();
    chk("R6 irq_stop off", irq_stop, 0);
    en_stop = 0;
  endtask

  task automatic clear_sticky();
    stat_rd = 1; step(); stat_rd = 0;
    stat_wr = 1; stat_wdata = 3'b000; step(); stat_wr = 0;
    step();
  endtask

  task automatic t_nack();
    en_nack = 1;
    ev_nack = 1; step(); ev_nack = 0; step();
    chk("R8 nack request", {status_o[4], irq_nack}, 2'b11);
    clear_sticky();
    chk("R8 nack cleared", {status_o[5:3], irq_nack}, 4'b0);
    ev_overrun = 1; step(); ev_overrun = 0; step();
    chk("R8 overrun request", {status_o[5], irq_nack}, 2'b11);
    mode_i2c = 0; step(2);
    chk("R7 nack gated", irq_nack, 0);
    mode_i2c = 1;
    clear_sticky();
    ev_arb_lost = 1; step(); ev_arb_lost = 0; step();
    chk("R8 arb request", {status_o[5], irq_nack}, 2'b11);
    clear_sticky();
    chk("R8 all clear", {status_o[5:3], irq_nack}, 4'b0);
  endtask

  initial begin
    step(4);
    rst_n = 1;
    step();
    t_reset();
    t_tx_empty();
    t_tx_end();
    t_rx_full();
    t_ctrl_access();
    t_mode();
    t_sticky();
    t_nack();
    report();
  end

  initial begin
    #(100000 * 5.0);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule